// File: doc/BRIEF.md
# Grouped Wake-Up Edge and Level Detector

This block watches a bank of asynchronous wake-up lines, arranged in groups of eight, and turns chosen transitions or levels on them into latched pending flags. Each line first passes through a multi-flop synchroniser. Detection then runs on the synchronised value. Every line has four control bits of its own:

- a mode bit that picks edge or level detection;
- a polarity bit that picks rising or falling edge, or active-high or active-low level;
- an either-edge override;
- an enable.

A pending flag, once set, stays set until software clears it. To clear flags, software writes ones to a separate clear register of the group. The usual handling sequence is to read a group's pending byte, write that same byte to the group's clear register, and then service each flagged line. Each group drives one interrupt line. That line is high while any flag in the group is both pending and enabled.

All configuration goes through a small register port. A write is a single cycle with `reg_wr` high. A read is combinational from `reg_addr`. The upper address bits select the group. The low three bits select the register:

| Low bits | Register | Access |
|---|---|---|
| 0 | mode | read/write |
| 1 | polarity | read/write |
| 2 | either-edge | read/write |
| 3 | enable | read/write |
| 4 | pending | read only |
| 5 | clear | write only, reads 0 |
| 6, 7 | unused | read 0, writes ignored |

Bit b of each register belongs to line b of the group. Line b of group g is `wake_in[8*g+b]`.

The datapath has no state machine beyond the per-line pending flags. It has no named states or transitions.

Top module: `wkup_edge_bank`

## Requirements
- R1: While reset is asserted, `grp_irq` is 0 and every register address reads 0. After reset, all configuration and pending bits are 0.
- R2: Mode, polarity, either-edge and enable (low bits 0–3) read back the last value written to them. A write to the pending address (4) has no effect. The clear address (5) always reads 0.
- R3: In edge mode with either-edge 0 and polarity 0, an enabled line sets its pending bit on a 0→1 transition. A 1→0 transition or a steady input leaves the bit clear.
- R4: In edge mode with either-edge 0 and polarity 1, an enabled line sets its pending bit on a 1→0 transition only.
- R5: When either-edge is 1 in edge mode, both transitions set the pending bit, for either polarity value.
- R6: A line whose enable bit is 0 never sets its pending bit, whatever its input or other controls.
- R7: Writing the clear register clears exactly the pending bits where the written data has a 1. Bits written 0 are unchanged.
- R8: A detection in the same cycle as a clear write to that bit leaves the pending bit set.
- R9: In level mode (mode bit 1), the pending bit is set in every cycle that the synchronised input is at its active level: high for polarity 0, low for polarity 1. A clear during the active level therefore does not remove the bit.
- R10: `grp_irq[g]` is high exactly while group g has a bit that is both pending and enabled. Clearing an enable masks the interrupt but keeps the pending bit. Groups are independent.
- R11: An input change made between clock edges shows in the pending register after the third following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_in | input | NUM_GROUPS*8 | Asynchronous wake-up lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | clog2(NUM_GROUPS)+3 | Register address: group index above a 3-bit register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| grp_irq | output | NUM_GROUPS | Per-group interrupt |

## Verification
One line is driven through each start and end level under every combination of mode, polarity, either-edge and enable. This separates rising from falling detection, shows the either-edge override beating the polarity bit, and shows that level detection differs from edge detection. Multi-bit patterns on a second group show that a clear touches only its one-bits, and that group interrupts stay separate. Timed directed cases cover the synchroniser latency and a clear that lands in the same cycle as an edge. A clear during an active level shows the pending bit re-asserting.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    localparam int GRP_W = 8;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 3'd0,
        SEL_POL  = 3'd1,
        SEL_ANY  = 3'd2,
        SEL_EN   = 3'd3,
        SEL_PEND = 3'd4,
        SEL_CLR  = 3'd5
    } wk_sel_e;

    typedef struct packed {
        logic [GRP_W-1:0] mode;
        logic [GRP_W-1:0] pol;
        logic [GRP_W-1:0] any;
        logic [GRP_W-1:0] en;
    } wk_cfg_t;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wkup_group.sv
module wkup_group
    import wkup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] sync_in,
    input  logic             wr_sel,
    input  logic [SEL_W-1:0] sel,
    input  logic [GRP_W-1:0] wdata,
    output wk_cfg_t          cfg,
    output logic [GRP_W-1:0] pend,
    output logic             irq
);
    logic [GRP_W-1:0] prev;
    logic [GRP_W-1:0] hit;
    logic [GRP_W-1:0] clr_mask;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_sel) begin
            case (sel)
                SEL_MODE: cfg.mode <= wdata;
                SEL_POL:  cfg.pol  <= wdata;
                SEL_ANY:  cfg.any  <= wdata;
                SEL_EN:   cfg.en   <= wdata;
                default:  ;
            endcase
        end
    end

    // previous synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sync_in;
    end

    for (genvar b = 0; b < GRP_W; b++) begin : g_det
        logic rise, fall, edge_hit, lvl_hit;
        always_comb begin
            rise     = sync_in[b] & ~prev[b];
            fall     = ~sync_in[b] & prev[b];
            edge_hit = cfg.any[b] ? (rise | fall) : (cfg.pol[b] ? fall : rise);
            lvl_hit  = cfg.pol[b] ? ~sync_in[b] : sync_in[b];
        end
        assign hit[b] = cfg.en[b] & (cfg.mode[b] ? lvl_hit : edge_hit);
    end

    assign clr_mask = (wr_sel && sel == SEL_CLR) ? wdata : '0;

    // new detections win over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | hit;
    end

    assign irq = |(pend & cfg.en);
endmodule

// File: rtl/wkup_edge_bank.sv
module wkup_edge_bank
    import wkup_pkg::*;
#(
    parameter int NUM_GROUPS  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int AW     = GIDX_W + SEL_W,
    localparam int NW     = NUM_GROUPS * GRP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         wake_in,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [GRP_W-1:0]      reg_wdata,
    output logic [GRP_W-1:0]      reg_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    logic [NW-1:0]     wake_s;
    logic [NW-1:0]     pend_all;
    logic [NW-1:0]     en_all;
    logic [GIDX_W-1:0] grp_idx;
    wk_cfg_t           cfg_arr  [NUM_GROUPS];
    logic [GRP_W-1:0]  pend_arr [NUM_GROUPS];

    assign grp_idx = reg_addr[AW-1:SEL_W];

    wkup_sync #(.W(NW), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(wake_in), .q(wake_s)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        wkup_group grp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (wake_s[g*GRP_W +: GRP_W]),
            .wr_sel  (reg_wr && grp_idx == GIDX_W'(g)),
            .sel     (reg_addr[SEL_W-1:0]),
            .wdata   (reg_wdata),
            .cfg     (cfg_arr[g]),
            .pend    (pend_arr[g]),
            .irq     (grp_irq[g])
        );
        assign pend_all[g*GRP_W +: GRP_W] = pend_arr[g];
        assign en_all[g*GRP_W +: GRP_W]   = cfg_arr[g].en;
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_idx == GIDX_W'(g)) begin
                case (reg_addr[SEL_W-1:0])
                    SEL_MODE: reg_rdata = cfg_arr[g].mode;
                    SEL_POL:  reg_rdata = cfg_arr[g].pol;
                    SEL_ANY:  reg_rdata = cfg_arr[g].any;
                    SEL_EN:   reg_rdata = cfg_arr[g].en;
                    SEL_PEND: reg_rdata = pend_arr[g];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/wkup_edge_bank_chk.sv
module wkup_edge_bank_chk
    import wkup_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int AW         = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [AW-1:0]               reg_addr,
    input logic [GRP_W-1:0]            reg_wdata,
    input logic [NUM_GROUPS*GRP_W-1:0] pend_all,
    input logic [NUM_GROUPS*GRP_W-1:0] en_all,
    input logic [NUM_GROUPS-1:0]       grp_irq
);
    for (genvar i = 0; i < NUM_GROUPS*GRP_W; i++) begin : g_bit
        localparam int G = i / GRP_W;
        localparam int B = i % GRP_W;
        localparam logic [AW-1:0] CLR_A = AW'((G << SEL_W) + int'(SEL_CLR));

        // R6
        pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_all[i]) |-> $past(en_all[i]));

        // R7
        pend_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_all[i]) |-> $past(reg_wr && reg_addr == CLR_A && reg_wdata[B]));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq
        // R10
        irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> (pend_all[g*GRP_W +: GRP_W] != '0));

        // R10
        irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[g*GRP_W +: GRP_W] == '0) |-> !grp_irq[g]);
    end
endmodule

bind wkup_edge_bank wkup_edge_bank_chk #(.NUM_GROUPS(NUM_GROUPS), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_all  (pend_all),
    .en_all    (en_all),
    .grp_irq   (grp_irq)
);

// File: tb/wkup_edge_bank_tb_top.sv
module wkup_edge_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 2;
    localparam int AW = 4;
    localparam int NV = 15;
    // fields: mode, pol, any, en, start level, end level, expected pending
    localparam logic [6:0] VEC [NV] = '{
        7'b0001_01_1, 7'b0001_10_0, 7'b0101_10_1, 7'b0101_01_0,
        7'b0011_01_1, 7'b0011_10_1, 7'b0111_01_1, 7'b0111_10_1,
        7'b0000_01_0, 7'b0010_10_0, 7'b1001_01_1, 7'b1001_00_0,
        7'b1101_10_1, 7'b1101_11_0, 7'b0001_00_0
    };

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NG*8-1:0] wake_in = '0;
    logic            reg_wr = 0;
    logic [AW-1:0]   reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NG-1:0]   grp_irq;
    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkup_edge_bank #(.NUM_GROUPS(NG), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grp_irq(grp_irq)
    );

    function automatic logic [AW-1:0] ra(int g, int s);
        return AW'(g*8 + s);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        idle(3);
        check("R1 irq", {6'd0, grp_irq}, 8'h00);
        for (int a = 0; a < 16; a++) begin
            rd(AW'(a), rv); check("R1 reg", rv, 8'h00);
        end
        rst_n = 1; idle(4);

        // R2 readback on group 1
        wr(ra(1,0), 8'hA5); wr(ra(1,1), 8'h3C); wr(ra(1,2), 8'h0F);
        rd(ra(1,0), rv); check("R2 mode", rv, 8'hA5);
        rd(ra(1,1), rv); check("R2 pol", rv, 8'h3C);
        rd(ra(1,2), rv); check("R2 any", rv, 8'h0F);
        wr(ra(1,4), 8'hFF);
        rd(ra(1,4), rv); check("R2 pend not writable", rv, 8'h00);
        rd(ra(1,5), rv); check("R2 clr reads 0", rv, 8'h00);
        wr(ra(1,0), 8'h00); wr(ra(1,1), 8'h00); wr(ra(1,2), 8'h00);

        // table walk on group 0 line 0
        for (int v = 0; v < NV; v++) begin
            logic [6:0] e;
            string tag;
            e = VEC[v];
            tag = e[6] ? "R9" : (!e[3] ? "R6" : (e[4] ? "R5" : (e[5] ? "R4" : "R3")));
            wr(ra(0,3), 8'h00);
            wake_in[0] = e[2]; idle(4);
            wr(ra(0,0), {7'd0, e[6]}); wr(ra(0,1), {7'd0, e[5]});
            wr(ra(0,2), {7'd0, e[4]}); wr(ra(0,3), {7'd0, e[3]});
            wr(ra(0,5), 8'hFF);
            wake_in[0] = e[1]; idle(4);
            rd(ra(0,4), rv); check(tag, rv, {7'd0, e[0]});
            check({tag, " irq"}, {7'd0, grp_irq[0]}, {7'd0, e[0]});
        end

        // R11 latency on group 1 line 2
        wr(ra(1,3), 8'h04); wr(ra(1,5), 8'hFF);
        wake_in[10] = 1;
        @(posedge clk); @(negedge clk); rd(ra(1,4), rv); check("R11 edge1", rv, 8'h00);
        @(posedge clk); @(negedge clk); rd(ra(1,4), rv); check("R11 edge2", rv, 8'h00);
        @(posedge clk); @(negedge clk); rd(ra(1,4), rv); check("R11 edge3", rv, 8'h04);
        check("R10 irq1 set", {6'd0, grp_irq}, 8'h02);

        // R10 masking keeps pending
        wr(ra(1,3), 8'h00);
        check("R10 masked", {6'd0, grp_irq}, 8'h00);
        rd(ra(1,4), rv); check("R10 pend kept", rv, 8'h04);
        wr(ra(1,3), 8'h04);
        check("R10 unmasked", {6'd0, grp_irq}, 8'h02);

        // R7 selective clear
        wr(ra(1,2), 8'hFF); wr(ra(1,3), 8'hFF); wr(ra(1,5), 8'hFF);
        wake_in[15:8] = 8'hF4; idle(4);
        rd(ra(1,4), rv); check("R7 multi", rv, 8'hF0);
        wr(ra(1,5), 8'h30); rd(ra(1,4), rv); check("R7 partial", rv, 8'hC0);
        wr(ra(1,5), 8'h00); rd(ra(1,4), rv); check("R7 zeros", rv, 8'hC0);
        check("R10 group0 quiet", {7'd0, grp_irq[0]}, 8'h00);
        wr(ra(1,5), 8'hC0); rd(ra(1,4), rv); check("R7 all", rv, 8'h00);
        check("R10 irq1 low", {7'd0, grp_irq[1]}, 8'h00);

        // R8 clear collides with edge on group 1 line 0
        wake_in[8] = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_wr = 1; reg_addr = ra(1,5); reg_wdata = 8'h01;
        @(posedge clk); @(negedge clk); reg_wr = 0;
        rd(ra(1,4), rv); check("R8 edge wins", rv, 8'h01);
        wr(ra(1,5), 8'h01); rd(ra(1,4), rv); check("R7 later clear", rv, 8'h00);

        // R9 level re-assert
        wr(ra(0,3), 8'h00); wr(ra(0,0), 8'h01); wr(ra(0,1), 8'h00); wr(ra(0,2), 8'h00);
        wake_in[0] = 1; wr(ra(0,3), 8'h01); idle(4);
        wr(ra(0,5), 8'h01); rd(ra(0,4), rv); check("R9 reassert", rv, 8'h01);
        wr(ra(0,1), 8'h01); wr(ra(0,5), 8'h01);
        rd(ra(0,4), rv); check("R9 inactive clear", rv, 8'h00);
        wake_in[0] = 0; idle(4);
        rd(ra(0,4), rv); check("R9 low active", rv, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule